// File: doc/BRIEF.md
# Checksummed Heap Header Recovery Scanner

After a restart, this block walks a persistent heap region and recovers its allocation layout from the headers stored at the front of each block. The heap is made of 64-byte lines. Every block starts with a one-word header that records the block length in lines, an allocated/free flag, and an 8-bit checksum. The checksum also folds in the block's line offset from the heap start, so a header copied or written to the wrong place does not pass the check.

A start pulse latches a base line address and a region length in lines. The scanner then fetches one candidate header at a time through a single-outstanding read port. When a header checks out, the scanner reports a block and jumps over it. When it does not, the scanner reports a corrupt line and steps forward by one line. Stepping one line at a time lets it find the next good header and pick up the walk again. A done flag rises once the walk reaches the end of the region.

Top module: `heap_hdr_walker`

## Requirements
- R1: While reset is held and directly after it, `done`, `rd_req`, `blk_stb` and `bad_stb` are all 0.
- R2: A header word holds the block size in lines in bits [15:0] and the state in bit 16 (1 = allocated). Bits [23:17] are ignored, and the stored checksum sits in bits [31:24]. The expected checksum is an 8-bit fold that starts at 0x5A. It runs over the 48-bit value {7 zero bits, state, size, line offset zero-extended to 24 bits}, taking bytes from the least significant one upward. For each byte it rotates the accumulator left by one bit and then XORs in the byte.
- R3: A start pulse seen while idle or done begins a walk at line offset 0. Each header fetch raises `rd_req` for exactly one cycle at address `base_line + offset`, and the next fetch is not issued until `rd_valid` has returned the word.
- R4: A header whose checksum matches, whose size is nonzero and which ends at or before the region end produces one `blk_stb` cycle. That cycle carries `ev_off`, `blk_size` and `blk_alloc`, and the next candidate is offset + size.
- R5: A header whose stored checksum differs from the expected one produces one `bad_stb` cycle with `ev_off` set to its offset, and the next candidate is offset + 1.
- R6: A header with a correct checksum but a size of zero, or one that would extend past the region end, is reported as corrupt in the same way as R5.
- R7: `done` rises in the cycle of the last strobe, when the next candidate equals the region length, and stays high until the next start. A start with a region length of 0 sets `done` without issuing any fetch.
- R8: Each returned header word produces exactly one strobe, and `blk_stb` and `bad_stb` are never high together.
- R9: A start pulse during a walk is ignored, and the walk in progress finishes with the base and length latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (when idle or done) |
| base_line | input | AW | Line address of the heap start |
| region_lines | input | OFF_W | Region length in lines |
| rd_req | output | 1 | One-cycle header fetch request |
| rd_addr | output | AW | Line address of the fetch |
| rd_valid | input | 1 | Fetched word is present on `rd_data` |
| rd_data | input | 32 | Fetched header word |
| blk_stb | output | 1 | Valid block found |
| bad_stb | output | 1 | Corrupt header line found |
| ev_off | output | OFF_W | Line offset of the reported event |
| blk_size | output | 16 | Decoded block size in lines |
| blk_alloc | output | 1 | Decoded allocation state |
| done | output | 1 | Walk finished |

## Verification
The bench builds the block with OFF_W = 8 and AW = 10. With these values the largest region, 255 lines, can be walked fully in a few thousand cycles. A single header whose size field (256) exceeds the offset width is also reachable, so the bench checks both a block ending exactly on the top line and an oversized header rejected as overrun. A 10-bit address space lets the same layout sit at a nonzero base, which shows that the checksum uses the relative offset. The memory model's read latency is varied between one and three cycles to cover the wait on `rd_valid`.

// File: rtl/heap_hdr_walker.sv
module heap_hdr_walker #(
  parameter int OFF_W = 12,
  parameter int AW    = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_line,
  input  logic [OFF_W-1:0] region_lines,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic             blk_stb,
  output logic             bad_stb,
  output logic [OFF_W-1:0] ev_off,
  output logic [15:0]      blk_size,
  output logic             blk_alloc,
  output logic             done
);
  localparam int EW = ((OFF_W > 16) ? OFF_W : 16) + 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;

  st_t              st;
  logic [OFF_W-1:0] off, lim, nxt_off;
  logic [AW-1:0]    base_q;
  logic [EW-1:0]    end_pos;
  logic             sum_ok, fits, good;
  logic             unused_rsvd;

  function automatic logic [7:0] hdr_sum(input logic [15:0] sz, input logic al,
                                         input logic [OFF_W-1:0] o);
    logic [47:0] v;
    logic [7:0]  acc;
    v   = {7'd0, al, sz, 24'(o)};
    acc = 8'h5A;
    for (int i = 0; i < 6; i++)
      acc = {acc[6:0], acc[7]} ^ v[8*i +: 8];
    return acc;
  endfunction

  assign unused_rsvd = ^rd_data[23:17];
  assign sum_ok  = hdr_sum(rd_data[15:0], rd_data[16], off) == rd_data[31:24];
  assign end_pos = EW'(off) + EW'(rd_data[15:0]);
  assign fits    = (rd_data[15:0] != 16'd0) && (end_pos <= EW'(lim));
  assign good    = sum_ok && fits;
  assign nxt_off = good ? end_pos[OFF_W-1:0] : off + 1'b1;

  assign rd_req  = (st == S_REQ);
  assign rd_addr = base_q + AW'(off);
  assign done    = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      off       <= '0;
      lim       <= '0;
      base_q    <= '0;
      blk_stb   <= 1'b0;
      bad_stb   <= 1'b0;
      ev_off    <= '0;
      blk_size  <= '0;
      blk_alloc <= 1'b0;
    end else begin
      blk_stb <= 1'b0;
      bad_stb <= 1'b0;
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            off    <= '0;
            lim    <= region_lines;
            base_q <= base_line;
            st     <= (region_lines == '0) ? S_DONE : S_REQ;
          end
        S_REQ: st <= S_WAIT;
        S_WAIT:
          if (rd_valid) begin
            ev_off    <= off;
            blk_size  <= rd_data[15:0];
            blk_alloc <= rd_data[16];
            blk_stb   <= good;
            bad_stb   <= !good;
            off       <= nxt_off;
            st        <= (nxt_off == lim) ? S_DONE : S_REQ;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_stb && bad_stb));

  // R8
  strobe_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_stb || bad_stb) |-> $past(rd_valid));

  // R3
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R7
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  // R4
  blk_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stb |-> blk_size != 16'd0);

  // R6
  blk_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stb |-> (EW'(ev_off) + EW'(blk_size) <= EW'(lim)));
endmodule

// File: tb/sim_heap_hdr_walker.sv
module sim_heap_hdr_walker;
  localparam int OFF_W = 8;
  localparam int AW    = 10;
  localparam int NEV   = 512;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [AW-1:0]    base_line = '0;
  logic [OFF_W-1:0] region_lines = '0;
  logic             rd_req, rd_valid = 1'b0;
  logic [AW-1:0]    rd_addr;
  logic [31:0]      rd_data = '0;
  logic             blk_stb, bad_stb, blk_alloc, done;
  logic [OFF_W-1:0] ev_off;
  logic [15:0]      blk_size;

  heap_hdr_walker #(.OFF_W(OFF_W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_line(base_line),
    .region_lines(region_lines), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .blk_stb(blk_stb),
    .bad_stb(bad_stb), .ev_off(ev_off), .blk_size(blk_size),
    .blk_alloc(blk_alloc), .done(done));

  always #10 clk = ~clk;

  int total = 0, fails = 0;
  logic [31:0] mem [0:(1<<AW)-1];
  int lat = 1;
  int nreads = 0;
  logic pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  int cnt = 0;

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      nreads <= nreads + 1;
      pend   <= 1'b1;
      paddr  <= rd_addr;
      cnt    <= lat - 1;
    end else if (pend) begin
      if (cnt == 0) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[paddr];
        pend     <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  int got_n = 0;
  int got_k [NEV];
  int got_o [NEV];
  int got_s [NEV];
  int got_a [NEV];
  always @(negedge clk) begin
    if (blk_stb || bad_stb) begin
      if (got_n < NEV) begin
        got_k[got_n] = blk_stb ? (bad_stb ? 2 : 1) : 0;
        got_o[got_n] = ev_off;
        got_s[got_n] = blk_size;
        got_a[got_n] = blk_alloc;
      end
      got_n++;
    end
  end

  int exp_n = 0;
  int exp_k [NEV];
  int exp_o [NEV];
  int exp_s [NEV];
  int exp_a [NEV];

  function automatic logic [7:0] ref_sum(int sz, int al, int o);
    logic [47:0] v;
    logic [7:0]  a;
    v = {7'd0, al[0], sz[15:0], o[23:0]};
    a = 8'h5A;
    for (int i = 0; i < 6; i++) a = {a[6:0], a[7]} ^ v[8*i +: 8];
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1<<AW); i++) mem[i] = 32'd0;
  endtask

  task automatic put_hdr(int base, int o, int sz, int al, bit corrupt, int rsvd = 0);
    logic [7:0] c;
    c = ref_sum(sz, al, o) ^ (corrupt ? 8'h01 : 8'h00);
    mem[base + o] = {c, rsvd[6:0], al[0], sz[15:0]};
  endtask

  task automatic model(int base, int lim);
    int o = 0;
    exp_n = 0;
    while (o < lim) begin
      logic [31:0] w;
      int sz, al;
      w  = mem[base + o];
      sz = w[15:0];
      al = w[16];
      if (w[31:24] == ref_sum(sz, al, o) && sz != 0 && o + sz <= lim) begin
        exp_k[exp_n] = 1; exp_o[exp_n] = o; exp_s[exp_n] = sz; exp_a[exp_n] = al;
        o += sz;
      end else begin
        exp_k[exp_n] = 0; exp_o[exp_n] = o; exp_s[exp_n] = 0; exp_a[exp_n] = 0;
        o += 1;
      end
      exp_n++;
    end
  endtask

  task automatic run_scan(int base, int lim, int poke_at = -1);
    int cyc = 0;
    got_n = 0;
    @(negedge clk);
    base_line = AW'(base); region_lines = OFF_W'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_line = '0; region_lines = OFF_W'(3);
    while (!done) begin
      if (cyc == poke_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(string tag);
    chk(got_n == exp_n, {tag, " event count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_k[i] == exp_k[i], {tag, " event kind (1=block,0=corrupt)"}, got_k[i], exp_k[i]);
      chk(got_o[i] == exp_o[i], {tag, " event offset"}, got_o[i], exp_o[i]);
      if (exp_k[i] == 1) begin
        chk(got_s[i] == exp_s[i], {tag, " block size"}, got_s[i], exp_s[i]);
        chk(got_a[i] == exp_a[i], {tag, " block state"}, got_a[i], exp_a[i]);
      end
    end
    chk(done == 1'b1, {tag, " done held"}, done, 1);
  endtask

  task automatic build_clean(int base);
    put_hdr(base, 0, 3, 0, 0);
    put_hdr(base, 3, 1, 1, 0);
    put_hdr(base, 4, 5, 1, 0, 7'h55);
    put_hdr(base, 9, 20, 0, 0);
    put_hdr(base, 29, 11, 1, 0);
  endtask

  task automatic t_reset();
    chk(done == 0 && rd_req == 0, "R1 done/rd_req after reset", {done, rd_req}, 0);
    chk(blk_stb == 0 && bad_stb == 0, "R1 strobes after reset", {blk_stb, bad_stb}, 0);
  endtask

  task automatic t_clean();
    clear_mem(); build_clean(0); model(0, 40);
    run_scan(0, 40);
    compare("R4 R2 clean walk");
    chk(exp_n == 5, "R4 model block count", exp_n, 5);
  endtask

  task automatic t_corrupt();
    clear_mem(); build_clean(0); put_hdr(0, 4, 5, 1, 1);
    model(0, 40);
    run_scan(0, 40);
    compare("R5 resync after bad checksum");
  endtask

  task automatic t_zero_size();
    clear_mem(); put_hdr(0, 0, 0, 1, 0); put_hdr(0, 1, 39, 0, 0);
    model(0, 40);
    run_scan(0, 40);
    compare("R6 zero size header");
  endtask

  task automatic t_overrun();
    clear_mem(); put_hdr(0, 0, 4, 1, 0); put_hdr(0, 4, 30, 0, 0);
    model(0, 20);
    run_scan(0, 20);
    compare("R6 overrun header");
  endtask

  task automatic t_edge();
    clear_mem(); put_hdr(0, 0, 256, 1, 0); put_hdr(0, 1, 254, 1, 0);
    model(0, 255);
    run_scan(0, 255);
    compare("R6 R7 oversize then block ending at region top");
  endtask

  task automatic t_base();
    clear_mem(); build_clean(0); build_clean(300);
    put_hdr(0, 0, 40, 1, 0);
    lat = 3;
    model(300, 40);
    run_scan(300, 40);
    compare("R3 nonzero base, slow reads");
    lat = 1;
  endtask

  task automatic t_empty();
    int r0;
    r0 = nreads;
    run_scan(0, 0);
    chk(nreads == r0, "R7 empty region issues no fetch", nreads - r0, 0);
    chk(got_n == 0, "R7 empty region gives no events", got_n, 0);
    chk(done == 1, "R7 empty region done", done, 1);
  endtask

  task automatic t_start_busy();
    int r0;
    clear_mem(); build_clean(0); put_hdr(0, 9, 20, 0, 1);
    model(0, 40);
    r0 = nreads;
    run_scan(0, 40, 6);
    compare("R9 start during walk ignored");
    chk(nreads - r0 == exp_n, "R8 one fetch per event", nreads - r0, exp_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    chk(done == 0 && rd_req == 0, "R1 outputs during reset", {done, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_corrupt();
    t_zero_size();
    t_overrun();
    t_edge();
    t_base();
    t_empty();
    t_start_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule